// File: doc/BRIEF.md
# Cartridge Bank Controller with Nine-Bit ROM Bank and Rumble Output

This block sits between a handheld console's CPU bus and the memories on a game cartridge. It watches CPU writes into the read-only program space and treats them as control writes. They set three things: a RAM enable, a nine-bit ROM bank number and a RAM bank number. For every bus address it then drives the upper ROM address bits, the upper RAM address bits and a RAM chip select. The memory arrays themselves are outside the block.

The lower 16 KiB program window always reads bank 0. The upper window reads whichever bank is selected, and bank 0 may also be placed there. The ROM bank number is written in two parts at two separate address ranges.

On a rumble cartridge one bit of the RAM bank write drives the vibration motor instead of the RAM address. All control writes take effect at the rising clock edge on which the write strobe is high. All address outputs follow the bus address combinationally.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled (`ram_cs` low everywhere) and `motor_on` is 0.
- R2: A write to $0000-$1FFF enables RAM only when the full data byte equals $0A. Any other byte, including $1A or $8A, disables it.
- R3: A write to $2000-$2FFF loads ROM bank bits 7-0 from the data byte and leaves bit 8 unchanged.
- R4: A write to $3000-$3FFF loads ROM bank bit 8 from data bit 0. Data bits 7-1 are ignored and bits 7-0 of the bank are unchanged.
- R5: `rom_hi_addr` is 0 for addresses $0000-$3FFF. For $4000-$7FFF it equals the selected 9-bit bank, with 0 passed through as 0. Above $7FFF it is 0.
- R6: A write to $4000-$5FFF loads the 4-bit RAM bank from data bits 3-0. With rumble enabled, `ram_hi_addr` is that bank with bit 3 forced to 0.
- R7: With rumble enabled, `motor_on` equals bit 3 of the last RAM bank write: 1 means on, 0 means off.
- R8: `ram_cs` is high only when the address is in $A000-$BFFF and RAM is enabled.
- R9: Writes to $6000-$7FFF and to $8000-$FFFF change no bank, enable or motor state.
- R10: While the write strobe is low, no state changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; control writes are taken on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, active high |
| rom_hi_addr | output | 9 | ROM address bits above the 16 KiB window offset |
| ram_hi_addr | output | 4 | RAM address bits above the 8 KiB window offset |
| ram_cs | output | 1 | External RAM chip select, active high |
| motor_on | output | 1 | Rumble motor enable |

## Verification
On every cycle, assertions check several properties. Each control write must land in its own register and leave the other part of the ROM bank alone. Only the exact enable key may enable RAM. With the strobe low, the state must hold. The fixed lower window must always output bank 0. The chip select must never fire outside its window or while RAM is disabled. A rising motor output must follow a RAM bank write. Only the bench scenarios can show the behaviour across several writes: a bank value carried through two separate part writes, bank 0 appearing in the upper window, and writes into unused ranges leaving every output unchanged.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // kind of control write seen on the bus in one cycle
  typedef enum logic [2:0] {
    WR_NONE     = 3'd0,
    WR_RAM_EN   = 3'd1,
    WR_ROM_LO   = 3'd2,
    WR_ROM_HI   = 3'd3,
    WR_RAM_BANK = 3'd4
  } wr_kind_e;

  // the only byte value that opens external RAM
  localparam logic [7:0] RAM_EN_KEY = 8'h0A;

endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
  import cbc_pkg::*;
(
  input  logic [3:0] addr_top,   // CPU address bits 15..12
  input  logic       wr,
  output wr_kind_e   kind
);

  // map the top nibble of a write address to a register target
  function automatic wr_kind_e decode_kind(input logic [3:0] top);
    unique casez (top)
      4'b000?: decode_kind = WR_RAM_EN;    // $0000-$1FFF
      4'b0010: decode_kind = WR_ROM_LO;    // $2000-$2FFF
      4'b0011: decode_kind = WR_ROM_HI;    // $3000-$3FFF
      4'b010?: decode_kind = WR_RAM_BANK;  // $4000-$5FFF
      default: decode_kind = WR_NONE;      // $6000-$FFFF
    endcase
  endfunction

  assign kind = wr ? decode_kind(addr_top) : WR_NONE;

endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
  import cbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROM_W  = 9,
  parameter int RAM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_kind_e          kind,
  input  logic [DATA_W-1:0] data,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAM_W-1:0]  ram_bank,
  output logic              ram_en
);

  localparam int HI_W = ROM_W - DATA_W;
  localparam logic [ROM_W-1:0] ROM_RST = ROM_W'(1);

  logic [DATA_W-1:0] rom_lo_q;
  logic [HI_W-1:0]   rom_hi_q;

  // event wires for the assertions
  logic ev_rom_lo, ev_rom_hi, ev_ram_bank, ev_ram_en, ev_idle;
  assign ev_rom_lo   = (kind == WR_ROM_LO);
  assign ev_rom_hi   = (kind == WR_ROM_HI);
  assign ev_ram_bank = (kind == WR_RAM_BANK);
  assign ev_ram_en   = (kind == WR_RAM_EN);
  assign ev_idle     = (kind == WR_NONE);

  function automatic logic key_match(input logic [DATA_W-1:0] d);
    key_match = (d == DATA_W'(RAM_EN_KEY));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_lo_q <= ROM_RST[DATA_W-1:0];
      rom_hi_q <= ROM_RST[ROM_W-1:DATA_W];
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      if (ev_rom_lo)   rom_lo_q <= data;
      if (ev_rom_hi)   rom_hi_q <= data[HI_W-1:0];
      if (ev_ram_bank) ram_bank <= data[RAM_W-1:0];
      if (ev_ram_en)   ram_en   <= key_match(data);
    end
  end

  assign rom_bank = {rom_hi_q, rom_lo_q};

  a_r3_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rom_lo |=> (rom_bank[DATA_W-1:0] == $past(data)) &&
                  (rom_bank[ROM_W-1:DATA_W] == $past(rom_bank[ROM_W-1:DATA_W])));

  a_r4_high_bit_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rom_hi |=> (rom_bank[ROM_W-1:DATA_W] == $past(data[HI_W-1:0])) &&
                  (rom_bank[DATA_W-1:0] == $past(rom_bank[DATA_W-1:0])));

  a_r2_exact_key: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ram_en |=> (ram_en == ($past(data) == DATA_W'(8'h0A))));

  a_r6_ram_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ram_bank |=> (ram_bank == $past(data[RAM_W-1:0])));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |=> $stable(rom_bank) && $stable(ram_bank) && $stable(ram_en));

endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map #(
  parameter int  ROM_W     = 9,
  parameter int  RAM_W     = 4,
  parameter bit  RUMBLE    = 1'b1,
  parameter int  MOTOR_BIT = 3
) (
  input  logic [2:0]       addr_top,   // CPU address bits 15..13
  input  logic [ROM_W-1:0] rom_bank,
  input  logic [RAM_W-1:0] ram_bank,
  input  logic             ram_en,
  output logic [ROM_W-1:0] rom_hi,
  output logic [RAM_W-1:0] ram_hi,
  output logic             ram_cs,
  output logic             motor
);

  // upper program window is $4000-$7FFF: bits 15..14 == 01
  function automatic logic [ROM_W-1:0] window_bank(input logic [2:0] top,
                                                   input logic [ROM_W-1:0] bank);
    window_bank = (top[2:1] == 2'b01) ? bank : '0;
  endfunction

  // external RAM window is $A000-$BFFF: bits 15..13 == 101
  function automatic logic in_ram_window(input logic [2:0] top);
    in_ram_window = (top == 3'b101);
  endfunction

  assign rom_hi = window_bank(addr_top, rom_bank);
  assign ram_cs = ram_en && in_ram_window(addr_top);

  generate
    if (RUMBLE) begin : g_rumble
      localparam logic [RAM_W-1:0] MOTOR_MASK = RAM_W'(1) << MOTOR_BIT;
      assign ram_hi = ram_bank & ~MOTOR_MASK;
      assign motor  = ram_bank[MOTOR_BIT];
    end else begin : g_plain
      assign ram_hi = ram_bank;
      assign motor  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_W     = 9,
  parameter int RAM_W     = 4,
  parameter bit RUMBLE    = 1'b1,
  parameter int MOTOR_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  output logic [ROM_W-1:0]  rom_hi_addr,
  output logic [RAM_W-1:0]  ram_hi_addr,
  output logic              ram_cs,
  output logic              motor_on
);

  wr_kind_e         wr_kind;
  logic [ROM_W-1:0] rom_bank;
  logic [RAM_W-1:0] ram_bank;
  logic             ram_en;

  // only the top address bits take part in decoding
  logic unused_addr_lo;
  assign unused_addr_lo = ^cpu_addr[ADDR_W-5:0];

  cbc_wr_decode u_decode (
    .addr_top (cpu_addr[ADDR_W-1 -: 4]),
    .wr       (cpu_wr),
    .kind     (wr_kind)
  );

  cbc_bank_regs #(
    .DATA_W (DATA_W),
    .ROM_W  (ROM_W),
    .RAM_W  (RAM_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (wr_kind),
    .data     (cpu_data),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_en   (ram_en)
  );

  cbc_addr_map #(
    .ROM_W     (ROM_W),
    .RAM_W     (RAM_W),
    .RUMBLE    (RUMBLE),
    .MOTOR_BIT (MOTOR_BIT)
  ) u_map (
    .addr_top (cpu_addr[ADDR_W-1 -: 3]),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_en   (ram_en),
    .rom_hi   (rom_hi_addr),
    .ram_hi   (ram_hi_addr),
    .ram_cs   (ram_cs),
    .motor    (motor_on)
  );

  a_r5_fixed_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] == 2'b00) |-> (rom_hi_addr == '0));

  a_r8_cs_window: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (ram_en && (cpu_addr[ADDR_W-1 -: 3] == 3'b101)));

  a_r9_upper_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[ADDR_W-1]) |-> (wr_kind == WR_NONE));

  a_r7_motor_from_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> $past(wr_kind == WR_RAM_BANK));

endmodule

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [8:0]  rom_hi_addr;
  logic [3:0]  ram_hi_addr;
  logic        ram_cs;
  logic        motor_on;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk, .rst_n, .cpu_addr, .cpu_data, .cpu_wr,
    .rom_hi_addr, .ram_hi_addr, .ram_cs, .motor_on
  );

  // behavioural reference state
  int m_rom = 1;
  int m_ram = 0;
  bit m_en  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rom <= 1; m_ram <= 0; m_en <= 0;
    end else if (cpu_wr) begin
      if (cpu_addr < 16'h2000)      m_en  <= (cpu_data == 8'h0A);
      else if (cpu_addr < 16'h3000) m_rom <= (m_rom / 256) * 256 + int'(cpu_data);
      else if (cpu_addr < 16'h4000) m_rom <= (m_rom % 256) + 256 * int'(cpu_data[0]);
      else if (cpu_addr < 16'h6000) m_ram <= int'(cpu_data) % 16;
    end
  end

  function automatic int exp_rom(int a);
    return (a >= 'h4000 && a < 'h8000) ? m_rom : 0;
  endfunction

  task automatic expect_eq(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_eq("R5", "model rom_hi", int'(rom_hi_addr), exp_rom(int'(cpu_addr)));
      expect_eq("R6", "model ram_hi", int'(ram_hi_addr), m_ram % 8);
      expect_eq("R7", "model motor", int'(motor_on), (m_ram / 8) % 2);
      expect_eq("R8", "model ram_cs", int'(ram_cs),
                int'(m_en && cpu_addr >= 16'hA000 && cpu_addr < 16'hC000));
    end
  end

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #2;
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(posedge clk); #2;
    cpu_wr = 1'b0;
  endtask

  task automatic look(logic [15:0] a);
    @(posedge clk); #2;
    cpu_addr = a;
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 3);
    rst_n = 1'b1;

    // R1 reset state
    look(16'h4000);
    expect_eq("R1", "reset rom bank", int'(rom_hi_addr), 1);
    expect_eq("R1", "reset ram bank", int'(ram_hi_addr), 0);
    expect_eq("R1", "reset motor", int'(motor_on), 0);
    look(16'hA000);
    expect_eq("R1", "reset ram_cs", int'(ram_cs), 0);

    // R2 exact key
    bus_write(16'h0000, 8'h0A); look(16'hA000);
    expect_eq("R2", "enable with 0A", int'(ram_cs), 1);
    bus_write(16'h1FFF, 8'h1A); look(16'hA000);
    expect_eq("R2", "1A disables", int'(ram_cs), 0);
    bus_write(16'h0123, 8'h0A); bus_write(16'h0000, 8'h8A); look(16'hA000);
    expect_eq("R2", "8A disables", int'(ram_cs), 0);
    bus_write(16'h0000, 8'h0A); bus_write(16'h0000, 8'h00); look(16'hBFFF);
    expect_eq("R2", "00 disables", int'(ram_cs), 0);

    // R3 / R4 split bank
    bus_write(16'h2000, 8'hA5); look(16'h4000);
    expect_eq("R3", "low byte", int'(rom_hi_addr), 'h0A5);
    bus_write(16'h3000, 8'h01); look(16'h7FFF);
    expect_eq("R4", "bit 8 set", int'(rom_hi_addr), 'h1A5);
    bus_write(16'h2FFF, 8'h3C); look(16'h5000);
    expect_eq("R3", "bit 8 kept", int'(rom_hi_addr), 'h13C);
    bus_write(16'h3FFF, 8'hFE); look(16'h4000);
    expect_eq("R4", "only data bit 0", int'(rom_hi_addr), 'h03C);

    // R5 window mapping
    look(16'h3FFF);
    expect_eq("R5", "low window bank 0", int'(rom_hi_addr), 0);
    look(16'h8000);
    expect_eq("R5", "above ROM is 0", int'(rom_hi_addr), 0);
    bus_write(16'h2000, 8'h00); look(16'h4000);
    expect_eq("R5", "bank 0 not remapped", int'(rom_hi_addr), 0);
    bus_write(16'h3000, 8'h01); bus_write(16'h2000, 8'hFF); look(16'h6000);
    expect_eq("R5", "bank 1FF", int'(rom_hi_addr), 'h1FF);

    // R6 / R7 RAM bank and motor
    bus_write(16'h4000, 8'h0F); look(16'hA000);
    expect_eq("R6", "bank masked", int'(ram_hi_addr), 7);
    expect_eq("R7", "motor on", int'(motor_on), 1);
    bus_write(16'h5FFF, 8'hF5); look(16'hA000);
    expect_eq("R6", "bank 5", int'(ram_hi_addr), 5);
    expect_eq("R7", "motor off", int'(motor_on), 0);

    // R8 chip-select window
    bus_write(16'h0000, 8'h0A);
    look(16'h9FFF); expect_eq("R8", "below window", int'(ram_cs), 0);
    look(16'hBFFF); expect_eq("R8", "window top", int'(ram_cs), 1);
    look(16'hC000); expect_eq("R8", "above window", int'(ram_cs), 0);

    // R9 ignored ranges
    bus_write(16'h6000, 8'h00); bus_write(16'h7FFF, 8'h00);
    bus_write(16'hA000, 8'h00); bus_write(16'hE000, 8'h00);
    look(16'h4000);
    expect_eq("R9", "rom bank kept", int'(rom_hi_addr), 'h1FF);
    expect_eq("R9", "ram bank kept", int'(ram_hi_addr), 5);
    look(16'hA000);
    expect_eq("R9", "enable kept", int'(ram_cs), 1);

    // R10 no strobe, no change
    @(posedge clk); #2;
    cpu_addr = 16'h2000; cpu_data = 8'h11; cpu_wr = 1'b0;
    repeat (2) @(posedge clk);
    #2 cpu_addr = 16'h0000; repeat (2) @(posedge clk);
    #2 cpu_addr = 16'h4000; cpu_data = 8'h08; repeat (2) @(posedge clk);
    look(16'h4000);
    expect_eq("R10", "rom unchanged", int'(rom_hi_addr), 'h1FF);
    expect_eq("R10", "motor unchanged", int'(motor_on), 0);
    look(16'hA000);
    expect_eq("R10", "enable unchanged", int'(ram_cs), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule